// File: doc/BRIEF.md
# Port Wake-Up and Hold-Release Controller

This block sits beside a small low-power processor core. It watches a 4-pin input port and turns pin activity into three kinds of event. A level change on a selected pin raises a one-cycle port interrupt and can end the core's hold (idle) state. A falling edge on a separately selected pin wakes the core from its stop state, and this works even while the main clock is halted. An 8-bit status register records which event source ended hold. Bit 0 belongs to the port-change source, and bits 7..1 belong to external sources that reach the block as plain event inputs.

Software sets two 4-bit masks with write-only loads. The first mask selects the pins that can raise the interrupt and end hold. The second selects the pins that can wake the core from stop. Software reads the status register one nibble at a time. It clears a status bit only as a side effect, by pulsing the matching event-clear line or by driving the matching hold-enable bit low; both of those registers live outside the block. While any status bit is set, a hold request is refused.

Top module: `port_wake_ctrl`

## Requirements
- R1: Once reset (synchronous, active-low `rst_n`) has been seen on a clock edge, both masks and all status bits are 0. `in_hold` and `port_irq` are 0, `rd_data` reads 0, and `stop_wake` is 0 from the first clock edge taken in reset.
- R2: A change in either direction on pin k while `chg_mask[k]` is 1 makes `port_irq` 1 for one cycle. `port_irq` is 0 after the second clock edge that follows the pin change and 1 after the third.
- R3: A change on a pin whose `chg_mask` bit is 0 leaves `port_irq` and status bit 0 unchanged.
- R4: Status bit 0 is set on the edge where `port_irq` rises, provided `hold_en[0]` is 1 when the change is detected. If `hold_en[0]` is 0, status bit 0 stays 0.
- R5: For n in 1..7, status bit n is set on the clock edge after a cycle in which `src_evt[n]` and `hold_en[n]` are both 1.
- R6: `rd_data` combinationally shows status bits 3..0 when `rd_lo` is 1, and bits 7..4 when only `rd_hi` is 1. It shows 0 when neither select is 1. `rd_lo` takes priority over `rd_hi`.
- R7: Status bit n is cleared on the edge after a cycle in which `hold_en[n]` is 0 or `evt_clr[n]` is 1. The clear wins over a set in the same cycle.
- R8: `in_hold` becomes 1 on the edge after `hold_req` is 1, if all status bits are 0. `hold_req` has no effect while any status bit is 1. `in_hold` drops on the edge after any status bit becomes 1.
- R9: While `stop_mode` is 1 and `wake_mask[k]` is 1, a falling edge on pin k drives `stop_wake` high at once, with no clock running. Rising edges, and pins whose mask bit is 0, do not set it.
- R10: `stop_wake` stays 1 until the first clock edge that samples `wake_ack` at 1. After that edge `stop_wake` reads 0.
- R11: A cycle with `chg_wr` loads `cfg_data` into `chg_mask`, and a cycle with `wake_wr` loads `cfg_data` into `wake_mask`. The loads take effect from the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 4 | Asynchronous port pins |
| chg_wr | input | 1 | Load the pin-change mask from `cfg_data` |
| wake_wr | input | 1 | Load the stop wake-up mask from `cfg_data` |
| cfg_data | input | 4 | Immediate mask value |
| hold_en | input | 8 | Per-source hold-enable bits, held in an external register |
| evt_clr | input | 8 | Per-source event-flag clear pulses |
| src_evt | input | 7 | Event inputs from the external sources, bits 7..1 |
| hold_req | input | 1 | Hold request from the core |
| stop_mode | input | 1 | Core is in stop mode |
| wake_ack | input | 1 | Core acknowledges stop wake-up |
| rd_lo | input | 1 | Read select for status bits 3..0 |
| rd_hi | input | 1 | Read select for status bits 7..4 |
| rd_data | output | 4 | Selected status nibble |
| in_hold | output | 1 | Core held idle |
| port_irq | output | 1 | Port-change interrupt pulse |
| stop_wake | output | 1 | Stop wake-up request |

## Verification
Four kinds of internal fault show at the ports:
- A synchronizer stage too many or too few moves the `port_irq` pulse off the third edge after a pin change. The fault shows on the first toggle.
- A wrong mask bit or gating term shows within three cycles, either as a missing or extra interrupt or as a wrong status nibble on `rd_data`.
- A broken clear shows on the next read after `evt_clr` or `hold_en` drops.
- A stuck capture flop shows as `stop_wake` being high without a falling edge, or staying high after the acknowledge edge.

Constrained-random pin, event and clear traffic is compared every cycle against a cycle model built from the requirements.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int unsigned PWC_PINS = 4;
    localparam int unsigned PWC_SRCS = 8;
endpackage

// File: rtl/pwc_pin_sync.sv
// Pin synchronizer and change detector.
// Two flops bring the asynchronous pins into the clock domain. A third flop keeps
// the previous synchronized sample, and any difference between the two is a change.
// Assumes each pin level is held for at least one clock period to be seen.
module pwc_pin_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_chg
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    // Shift the pins through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign pin_chg = cur_q ^ prev_q;

    // A change seen now must come from a pin that moved at least two edges earlier.
    p_chg_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_chg) |-> (prev_q == $past(cur_q)));
endmodule

// File: rtl/pwc_stop_catch.sv
// Stop-mode wake-up capture.
// Each pin has a flop clocked by its own falling edge, so a wake-up is caught with
// the main clock halted. The clear is a registered pulse driven by reset or by the
// core's acknowledge, and it acts asynchronously on the capture flops.
// Assumes the wake mask is stable while stop_mode is 1.
module pwc_stop_catch #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic         stop_mode,
    input  logic [W-1:0] wake_mask,
    input  logic         wake_ack,
    output logic         stop_wake
);
    logic         clr_q;
    logic [W-1:0] cap_vec;

    // Register the clear request so the async clear is free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b1;
        end else begin
            clr_q <= wake_ack;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_cap
        logic cap_bit;
        // Latch a falling edge on this pin while armed and in stop mode.
        always_ff @(negedge pin_in[g] or posedge clr_q) begin
            if (clr_q) begin
                cap_bit <= 1'b0;
            end else if (stop_mode && wake_mask[g]) begin
                cap_bit <= 1'b1;
            end
        end
        assign cap_vec[g] = cap_bit;
    end

    assign stop_wake = |cap_vec;

    // An acknowledge sampled on an edge leaves no wake request at the next edge.
    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> !stop_wake);
endmodule

// File: rtl/pwc_hold_status.sv
// Hold-release status register and hold state.
// Hardware sets each status bit from its gated source event. A status bit clears
// only when its hold-enable is low or its event-clear pulses, and the clear wins.
// Any set bit ends hold and blocks new hold requests.
// Assumes bit 0 is the port-change source and bits N-1..1 are external sources.
module pwc_hold_status #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_hit,
    input  logic [N-1:1] src_evt,
    input  logic [N-1:0] hold_en,
    input  logic [N-1:0] evt_clr,
    input  logic         hold_req,
    output logic [N-1:0] stat,
    output logic         in_hold
);
    logic [N-1:0] raw_set;
    logic [N-1:0] kill;

    assign raw_set = {src_evt, port_hit} & hold_en;
    assign kill    = ~hold_en | evt_clr;

    // Accumulate the gated events, with clears taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= (stat | raw_set) & ~kill;
        end
    end

    // Enter hold on request unless a release condition is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hold <= 1'b0;
        end else if (|stat) begin
            in_hold <= 1'b0;
        end else if (hold_req) begin
            in_hold <= 1'b1;
        end
    end

    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat) |=> !in_hold);
    p_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_hold) |-> $past(hold_req));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|kill) |=> ((stat & $past(kill)) == '0));
    p_set_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~$past(hold_en)) == '0));
endmodule

// File: rtl/port_wake_ctrl.sv
// Port wake-up and hold-release controller, top level.
// Holds the two write-only pin masks, raises the port-change interrupt, and ties
// together the synchronizer, the stop-mode capture and the status register.
// Assumes SRCS is even, so the status register splits into two read halves.
module port_wake_ctrl #(
    parameter int unsigned PINS = pwc_pkg::PWC_PINS,
    parameter int unsigned SRCS = pwc_pkg::PWC_SRCS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PINS-1:0]      pin_in,
    input  logic                 chg_wr,
    input  logic                 wake_wr,
    input  logic [PINS-1:0]      cfg_data,
    input  logic [SRCS-1:0]      hold_en,
    input  logic [SRCS-1:0]      evt_clr,
    input  logic [SRCS-1:1]      src_evt,
    input  logic                 hold_req,
    input  logic                 stop_mode,
    input  logic                 wake_ack,
    input  logic                 rd_lo,
    input  logic                 rd_hi,
    output logic [SRCS/2-1:0]    rd_data,
    output logic                 in_hold,
    output logic                 port_irq,
    output logic                 stop_wake
);
    localparam int unsigned HALF = SRCS / 2;

    logic [PINS-1:0] chg_mask;
    logic [PINS-1:0] wake_mask;
    logic [PINS-1:0] pin_chg;
    logic [SRCS-1:0] stat;
    logic            port_hit;

    // Load the masks from immediate writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_mask  <= '0;
            wake_mask <= '0;
        end else begin
            if (chg_wr)  chg_mask  <= cfg_data;
            if (wake_wr) wake_mask <= cfg_data;
        end
    end

    pwc_pin_sync #(.W(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .pin_chg (pin_chg)
    );

    assign port_hit = |(pin_chg & chg_mask);

    // Register the interrupt pulse for enabled pin changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_irq <= 1'b0;
        end else begin
            port_irq <= port_hit;
        end
    end

    pwc_hold_status #(.N(SRCS)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_hit (port_hit),
        .src_evt  (src_evt),
        .hold_en  (hold_en),
        .evt_clr  (evt_clr),
        .hold_req (hold_req),
        .stat     (stat),
        .in_hold  (in_hold)
    );

    pwc_stop_catch #(.W(PINS)) u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .stop_mode (stop_mode),
        .wake_mask (wake_mask),
        .wake_ack  (wake_ack),
        .stop_wake (stop_wake)
    );

    // Select the status nibble for the core, with the low half taking priority.
    always_comb begin
        if (rd_lo)      rd_data = stat[HALF-1:0];
        else if (rd_hi) rd_data = stat[SRCS-1:HALF];
        else            rd_data = '0;
    end

    p_irq_needs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        port_irq |-> ($past(chg_mask) != '0));
    p_port_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> port_irq);
endmodule

// File: tb/port_wake_ctrl_test.sv
`timescale 1ns/1ps
module port_wake_ctrl_test;
    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n;
    logic [3:0] pin_in;
    logic       chg_wr, wake_wr;
    logic [3:0] cfg_data;
    logic [7:0] hold_en, evt_clr;
    logic [7:1] src_evt;
    logic       hold_req, stop_mode, wake_ack, rd_lo, rd_hi;
    logic [3:0] rd_data;
    logic       in_hold, port_irq, stop_wake;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    port_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chg_wr(chg_wr), .wake_wr(wake_wr),
        .cfg_data(cfg_data), .hold_en(hold_en), .evt_clr(evt_clr), .src_evt(src_evt),
        .hold_req(hold_req), .stop_mode(stop_mode), .wake_ack(wake_ack),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data), .in_hold(in_hold),
        .port_irq(port_irq), .stop_wake(stop_wake)
    );

    always begin
        #2.5;
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] rd_model(input logic [7:0] s, input logic lo, input logic hi);
        if (lo) return s[3:0];
        if (hi) return s[7:4];
        return 4'h0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; pin_in = '0; chg_wr = 0; wake_wr = 0; cfg_data = '0;
        hold_en = 8'hFF; evt_clr = '0; src_evt = '0; hold_req = 0;
        stop_mode = 0; wake_ack = 0; rd_lo = 0; rd_hi = 0;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m_stat;
        logic [3:0] m_mask, s1, s2, s3;
        logic       m_hold, m_irq, hit;
        void'($urandom(32'h5EED_1234));
        do_reset();
        // R1 reset state
        chk("R1 irq", port_irq, 0);
        chk("R1 hold", in_hold, 0);
        chk("R1 wake", stop_wake, 0);
        rd_lo = 1; #1; chk("R1 lo", rd_data, 0);
        rd_lo = 0; rd_hi = 1; #1; chk("R1 hi", rd_data, 0);
        rd_hi = 0; rd_lo = 1;

        // R11 mask write, R2 timing of the interrupt pulse
        chg_wr = 1; cfg_data = 4'b0001; step(1); chg_wr = 0;
        pin_in[0] = 1; step(2); chk("R2 early", port_irq, 0);
        step(1); chk("R2 pulse", port_irq, 1);
        chk("R4 bit0 set", rd_data, 4'h1);
        step(1); chk("R2 one cycle", port_irq, 0);
        // R7 clear through evt_clr
        evt_clr[0] = 1; step(1); evt_clr[0] = 0;
        chk("R7 evt_clr", rd_data, 4'h0);
        // R2 falling change also counts
        pin_in[0] = 0; step(3); chk("R2 fall pulse", port_irq, 1);
        step(1);
        evt_clr[0] = 1; step(1); evt_clr[0] = 0;
        // R3 disabled pin ignored
        pin_in[1] = 1; step(3); chk("R3 irq", port_irq, 0);
        step(1); chk("R3 irq late", port_irq, 0); chk("R3 stat", rd_data, 4'h0);
        // R4 hold_en[0] low blocks the status bit but not the interrupt
        hold_en[0] = 0; pin_in[0] = 1; step(3);
        chk("R4 irq still", port_irq, 1); chk("R4 no bit", rd_data, 4'h0);
        hold_en[0] = 1; step(2);

        // R8 hold entry, release, refusal; R5 external source
        hold_req = 1; step(1); hold_req = 0;
        chk("R8 enter", in_hold, 1);
        rd_lo = 0; rd_hi = 1;
        src_evt[5] = 1; step(1); src_evt[5] = 0;
        chk("R5 bit5", rd_data, 4'h2);
        chk("R8 still", in_hold, 1);
        step(1); chk("R8 release", in_hold, 0);
        hold_req = 1; step(1); hold_req = 0;
        chk("R8 refused", in_hold, 0);
        hold_en[6] = 0; src_evt[6] = 1; step(1); src_evt[6] = 0; hold_en[6] = 1;
        chk("R5 gated", rd_data, 4'h2);
        // R6 read selects
        rd_hi = 0; #1; chk("R6 none", rd_data, 4'h0);
        rd_lo = 1; rd_hi = 1; #1; chk("R6 lo priority", rd_data, 4'h0);
        rd_lo = 0;
        // R7 hold_en low clears; clear beats set
        hold_en[5] = 0; step(1); hold_en[5] = 1;
        chk("R7 hold_en clr", rd_data, 4'h0);
        src_evt[5] = 1; evt_clr[5] = 1; step(1); src_evt[5] = 0; evt_clr[5] = 0;
        chk("R7 clear wins", rd_data, 4'h0);

        // R9 and R10 stop wake-up
        wake_wr = 1; cfg_data = 4'b0001; step(1); wake_wr = 0;
        pin_in = 4'b0000; step(2);
        stop_mode = 1;
        pin_in[0] = 1; step(2); chk("R9 rise", stop_wake, 0);
        pin_in[1] = 1; step(2);
        clk_run = 0; #10;
        pin_in[1] = 0; #3; chk("R9 unmasked", stop_wake, 0);
        pin_in[0] = 0; #3; chk("R9 fall no clock", stop_wake, 1);
        clk_run = 1; step(3); chk("R10 held", stop_wake, 1);
        wake_ack = 1; step(1); wake_ack = 0;
        chk("R10 ack", stop_wake, 0);
        step(1); chk("R10 stays low", stop_wake, 0);
        stop_mode = 0;

        // Random phase against a cycle model
        do_reset();
        m_stat = 0; m_mask = 0; s1 = 0; s2 = 0; s3 = 0; m_hold = 0; m_irq = 0;
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < 4; b++) if ($urandom_range(0, 2) == 0) pin_in[b] = ~pin_in[b];
            chg_wr   = ($urandom_range(0, 15) == 0);
            cfg_data = 4'($urandom);
            for (int b = 0; b < 8; b++) hold_en[b] = ($urandom_range(0, 7) != 0);
            for (int b = 0; b < 8; b++) evt_clr[b] = ($urandom_range(0, 15) == 0);
            for (int b = 1; b < 8; b++) src_evt[b] = ($urandom_range(0, 9) == 0);
            hold_req = ($urandom_range(0, 3) == 0);
            rd_lo = 1'($urandom); rd_hi = 1'($urandom);
            hit    = |((s2 ^ s3) & m_mask);
            m_irq  = hit;
            m_hold = (|m_stat) ? 1'b0 : (hold_req ? 1'b1 : m_hold);
            m_stat = (m_stat | ({src_evt, hit} & hold_en)) & ~(~hold_en | evt_clr);
            s3 = s2; s2 = s1; s1 = pin_in;
            if (chg_wr) m_mask = cfg_data;
            step(1);
            chk("R2 random irq", port_irq, m_irq);
            chk("R8 random hold", in_hold, m_hold);
            chk("R6 random read", rd_data, rd_model(m_stat, rd_lo, rd_hi));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule